// File: doc/BRIEF.md
# Output Fault Diagnostic Controller

This block is the digital fault-management core of a two-channel differential output driver. Comparator-level fault indications arrive per channel (short to supply, short to ground, current limit, excessive offset, open load) together with three global ones (temperature warning, thermal shutdown, supply overvoltage). Each indication is gated by the global diagnostic enable and by its own mask bit, then captured in a sticky status register. A register bus outside this block reads the status registers and pulses a clear strobe when a register is read.

The block decides what each fault does to the channels. A short turns the faulted channel off and tri-states it until software retries. An overvoltage does the same to both channels. An overcurrent only reports. The block also runs the per-channel open-load test window, and it combines the enable and mute bits with the shutdown and mute pins. It drives an open-drain style active-low fault flag and a readable copy of that flag. Every output is registered, and every reaction appears one clock after the input that causes it.

Top module: `fault_diag_ctrl`

## Requirements
- R1: A channel or temperature fault is captured only when `diag_en` is 1 and the matching mask bit is 1. The mask bits share bit positions with the status bits they enable.
- R2: Each channel status byte holds short-to-supply in bit 7, short-to-ground in bit 6, current limit in bit 5, excessive offset in bit 3 and open load in bit 2. Bits 4, 1 and 0 are always 0. Fault inputs use the same bit positions.
- R3: The general status byte holds temperature warning in bit 6, thermal shutdown in bit 5 and overvoltage in bit 4, and its other bits are 0. Overvoltage is captured whenever `diag_en` is 1, whatever its mask bit holds. Temperature faults do not switch any channel off.
- R4: A captured short to supply or to ground sets `ch_hiz` of that channel and clears its `ch_on` on the next clock. The channel stays that way until a retry pulse arrives.
- R5: A captured current-limit fault sets its status bit and pulls `flag_n` low, and the channel's `ch_on` stays 1.
- R6: An excessive-offset fault is captured only while the outputs are muted, that is while `mute_bit` is 1 or `mute_n` is 0.
- R7: A captured overvoltage sets `ch_hiz` and clears `ch_on` on every channel.
- R8: A 0-to-1 change of a channel's `ol_req`, with `diag_en` at 1, holds that channel's `ch_on` at 0 for exactly OL_CYCLES clocks. An open-load fault is captured only inside that window. Keeping `ol_req` at 1 does not start another test; it must return to 0 and rise again.
- R9: `flag_n` is 0 exactly when any bit of any status register is 1, and `flag_sum` is always the inverse of `flag_n`.
- R10: `ch_on` is 0 for all channels while `shdn_n` is 0 or `en_bit` is 0. `mute_out` is 1 while `mute_bit` is 1 or `mute_n` is 0.
- R11: A retry pulse clears `ch_hiz` only if the channel's short-to-supply and short-to-ground inputs and the overvoltage input are all inactive. Otherwise it has no effect.
- R12: A status bit stays set after its input goes away, until the register's clear strobe arrives. If the fault is still present during the clear, the bit stays set.
- R13: After reset all status bits, `ch_hiz` and `ch_on` are 0, `flag_n` is 1 and `mute_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| diag_en | input | 1 | Global diagnostic enable |
| en_bit | input | 1 | Device enable bit |
| shdn_n | input | 1 | Shutdown pin, low overrides enable |
| mute_bit | input | 1 | Mute bit |
| mute_n | input | 1 | Mute pin, low forces mute |
| ch_mask | input | NCH*8 | Per-channel detection masks, status layout |
| gen_mask | input | 8 | General detection mask, status layout |
| ch_fault_in | input | NCH*8 | Per-channel fault indications, status layout |
| twarn_in | input | 1 | Temperature warning indication |
| tshdn_in | input | 1 | Thermal shutdown indication |
| ovp_in | input | 1 | Supply overvoltage indication |
| ol_req | input | NCH | Open-load test request bits |
| retry | input | NCH | Retry pulses |
| clr_ch | input | NCH | Clear-on-read strobes, channel status |
| clr_gen | input | 1 | Clear-on-read strobe, general status |
| ch_status | output | NCH*8 | Channel status bytes (channel 0 in bits 7:0) |
| gen_status | output | 8 | General status byte |
| ch_hiz | output | NCH | Channel held off and tri-stated by a fault |
| ch_on | output | NCH | Channel driver enable |
| mute_out | output | 1 | Effective mute |
| flag_n | output | 1 | Active-low fault flag |
| flag_sum | output | 1 | Readable summary, 1 while flag_n is low |

## Verification
The assertions watch, on every cycle, the relations that hold at any moment. A short or an overvoltage must be followed by tri-state. A tri-stated channel must never be driving. A blocked retry must leave the channel off. Status bits must stay sticky, the unused bits must stay zero, and the flag must match the status contents. Shutdown must turn the drivers off, and offset must never be captured while unmuted. Only the bench's scenarios can show the exact length of the open-load window and that it does not restart while the request stays high. They also show the mask gating of each class, a successful retry once the fault has cleared, the clear-versus-set collision, and the reset values.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int BW = 8;
  localparam int B_SVDD  = 7;
  localparam int B_SGND  = 6;
  localparam int B_ILIM  = 5;
  localparam int B_OFFS  = 3;
  localparam int B_OPEN  = 2;
  localparam int B_TWARN = 6;
  localparam int B_TSHDN = 5;
  localparam int B_OVP   = 4;
endpackage

// File: rtl/fdc_chan.sv
module fdc_chan
  import fdc_pkg::*;
#(
  parameter int OL_CYCLES = 250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          diag_en,
  input  logic          mute_eff,
  input  logic          dev_en,
  input  logic [BW-1:0] fault_in,
  input  logic [BW-1:0] mask,
  input  logic          ol_req,
  input  logic          retry,
  input  logic          clr,
  input  logic          ovp_trip,
  input  logic          ovp_raw,
  output logic [BW-1:0] status,
  output logic [BW-1:0] status_nxt,
  output logic          hiz,
  output logic          drv_on
);
  localparam int CW = $clog2(OL_CYCLES + 1);

  logic          req_q;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          ol_win, ol_start;
  logic [BW-1:0] det;
  logic          hiz_nxt, short_hit, retry_ok;

  assign ol_win   = (cnt != '0);
  assign ol_start = ol_req & ~req_q & diag_en & ~ol_win;

  always_comb begin
    if (ol_start)    cnt_nxt = CW'(OL_CYCLES);
    else if (ol_win) cnt_nxt = cnt - CW'(1);
    else             cnt_nxt = '0;
  end

  always_comb begin
    det = '0;
    det[B_SVDD] = fault_in[B_SVDD] & mask[B_SVDD];
    det[B_SGND] = fault_in[B_SGND] & mask[B_SGND];
    det[B_ILIM] = fault_in[B_ILIM] & mask[B_ILIM];
    det[B_OFFS] = fault_in[B_OFFS] & mask[B_OFFS] & mute_eff;
    det[B_OPEN] = fault_in[B_OPEN] & mask[B_OPEN] & ol_win;
    det = det & {BW{diag_en}};
  end

  assign status_nxt = (clr ? '0 : status) | det;
  assign short_hit  = det[B_SVDD] | det[B_SGND];
  assign retry_ok   = retry & ~fault_in[B_SVDD] & ~fault_in[B_SGND] & ~ovp_raw;

  always_comb begin
    if (short_hit | ovp_trip) hiz_nxt = 1'b1;
    else if (retry_ok)        hiz_nxt = 1'b0;
    else                      hiz_nxt = hiz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      cnt    <= '0;
      status <= '0;
      hiz    <= 1'b0;
      drv_on <= 1'b0;
    end else begin
      req_q  <= ol_req;
      cnt    <= cnt_nxt;
      status <= status_nxt;
      hiz    <= hiz_nxt;
      drv_on <= dev_en & ~hiz_nxt & (cnt_nxt == '0);
    end
  end
endmodule

// File: rtl/fdc_global.sv
module fdc_global
  import fdc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          diag_en,
  input  logic [BW-1:0] gen_mask,
  input  logic          twarn_in,
  input  logic          tshdn_in,
  input  logic          ovp_in,
  input  logic          clr,
  output logic [BW-1:0] status,
  output logic [BW-1:0] status_nxt,
  output logic          ovp_trip
);
  logic [BW-1:0] det;

  assign ovp_trip = diag_en & ovp_in;

  always_comb begin
    det = '0;
    det[B_TWARN] = diag_en & gen_mask[B_TWARN] & twarn_in;
    det[B_TSHDN] = diag_en & gen_mask[B_TSHDN] & tshdn_in;
    det[B_OVP]   = ovp_trip;
  end

  assign status_nxt = (clr ? '0 : status) | det;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_nxt;
  end
endmodule

// File: rtl/fdc_flag.sv
module fdc_flag
  import fdc_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*BW-1:0] ch_nxt,
  input  logic [BW-1:0]     gen_nxt,
  output logic              flag_n,
  output logic              flag_sum
);
  logic any_set;
  assign any_set = (|ch_nxt) | (|gen_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n   <= 1'b1;
      flag_sum <= 1'b0;
    end else begin
      flag_n   <= ~any_set;
      flag_sum <= any_set;
    end
  end
endmodule

// File: rtl/fault_diag_ctrl.sv
module fault_diag_ctrl
  import fdc_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int OL_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              diag_en,
  input  logic              en_bit,
  input  logic              shdn_n,
  input  logic              mute_bit,
  input  logic              mute_n,
  input  logic [NCH*BW-1:0] ch_mask,
  input  logic [BW-1:0]     gen_mask,
  input  logic [NCH*BW-1:0] ch_fault_in,
  input  logic              twarn_in,
  input  logic              tshdn_in,
  input  logic              ovp_in,
  input  logic [NCH-1:0]    ol_req,
  input  logic [NCH-1:0]    retry,
  input  logic [NCH-1:0]    clr_ch,
  input  logic              clr_gen,
  output logic [NCH*BW-1:0] ch_status,
  output logic [BW-1:0]     gen_status,
  output logic [NCH-1:0]    ch_hiz,
  output logic [NCH-1:0]    ch_on,
  output logic              mute_out,
  output logic              flag_n,
  output logic              flag_sum
);
  logic              mute_eff, dev_en, ovp_trip;
  logic [NCH*BW-1:0] ch_nxt;
  logic [BW-1:0]     gen_nxt;

  assign mute_eff = mute_bit | ~mute_n;
  assign dev_en   = en_bit & shdn_n;

  always_ff @(posedge clk) begin
    if (rst) mute_out <= 1'b1;
    else     mute_out <= mute_eff;
  end

  fdc_global u_gen (
    .clk(clk), .rst(rst), .diag_en(diag_en), .gen_mask(gen_mask),
    .twarn_in(twarn_in), .tshdn_in(tshdn_in), .ovp_in(ovp_in),
    .clr(clr_gen), .status(gen_status), .status_nxt(gen_nxt),
    .ovp_trip(ovp_trip)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fdc_chan #(.OL_CYCLES(OL_CYCLES)) u_ch (
      .clk(clk), .rst(rst), .diag_en(diag_en), .mute_eff(mute_eff),
      .dev_en(dev_en),
      .fault_in(ch_fault_in[c*BW +: BW]),
      .mask(ch_mask[c*BW +: BW]),
      .ol_req(ol_req[c]), .retry(retry[c]), .clr(clr_ch[c]),
      .ovp_trip(ovp_trip), .ovp_raw(ovp_in),
      .status(ch_status[c*BW +: BW]),
      .status_nxt(ch_nxt[c*BW +: BW]),
      .hiz(ch_hiz[c]), .drv_on(ch_on[c])
    );
  end

  fdc_flag #(.NCH(NCH)) u_flag (
    .clk(clk), .rst(rst), .ch_nxt(ch_nxt), .gen_nxt(gen_nxt),
    .flag_n(flag_n), .flag_sum(flag_sum)
  );
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker
  import fdc_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              diag_en,
  input logic              en_bit,
  input logic              shdn_n,
  input logic              mute_bit,
  input logic              mute_n,
  input logic [NCH*BW-1:0] ch_mask,
  input logic [NCH*BW-1:0] ch_fault_in,
  input logic              ovp_in,
  input logic [NCH-1:0]    clr_ch,
  input logic [NCH*BW-1:0] ch_status,
  input logic [BW-1:0]     gen_status,
  input logic [NCH-1:0]    ch_hiz,
  input logic [NCH-1:0]    ch_on,
  input logic              flag_n,
  input logic              flag_sum
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    p_short_hiz_r4: assert property (@(posedge clk) disable iff (rst)
      (diag_en && ch_mask[c*BW+B_SVDD] && ch_fault_in[c*BW+B_SVDD]) |=> ch_hiz[c]);
    p_hiz_off_r4: assert property (@(posedge clk) disable iff (rst)
      ch_hiz[c] |-> !ch_on[c]);
    p_retry_block_r11: assert property (@(posedge clk) disable iff (rst)
      (ch_hiz[c] && (ch_fault_in[c*BW+B_SVDD] || ch_fault_in[c*BW+B_SGND] || ovp_in))
      |=> ch_hiz[c]);
    p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
      (ch_status[c*BW+B_ILIM] && !clr_ch[c]) |=> ch_status[c*BW+B_ILIM]);
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
      !(ch_status[c*BW+4] || ch_status[c*BW+1] || ch_status[c*BW+0]));
    p_offs_unmuted_r6: assert property (@(posedge clk) disable iff (rst)
      (mute_bit == 1'b0 && mute_n && !ch_status[c*BW+B_OFFS]) |=> !ch_status[c*BW+B_OFFS]);
  end

  p_ovp_all_hiz_r7: assert property (@(posedge clk) disable iff (rst)
    (diag_en && ovp_in) |=> (ch_hiz == {NCH{1'b1}}));
  p_flag_match_r9: assert property (@(posedge clk) disable iff (rst)
    flag_n == ((ch_status == '0) && (gen_status == '0)));
  p_flag_sum_r9: assert property (@(posedge clk) disable iff (rst)
    flag_sum != flag_n);
  p_shdn_off_r10: assert property (@(posedge clk) disable iff (rst)
    (!shdn_n || !en_bit) |=> (ch_on == '0));
endmodule

bind fault_diag_ctrl fdc_checker #(.NCH(NCH)) i_chk (
  .clk(clk), .rst(rst), .diag_en(diag_en), .en_bit(en_bit), .shdn_n(shdn_n),
  .mute_bit(mute_bit), .mute_n(mute_n), .ch_mask(ch_mask),
  .ch_fault_in(ch_fault_in), .ovp_in(ovp_in), .clr_ch(clr_ch),
  .ch_status(ch_status), .gen_status(gen_status), .ch_hiz(ch_hiz),
  .ch_on(ch_on), .flag_n(flag_n), .flag_sum(flag_sum)
);

// File: tb/test_fault_diag_ctrl.sv
module test_fault_diag_ctrl;
  localparam int NCH = 2;
  localparam int OLC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic diag_en = 1'b0, en_bit = 1'b1, shdn_n = 1'b1, mute_bit = 1'b0, mute_n = 1'b1;
  logic [15:0] ch_mask = 16'hFFFF;
  logic [7:0]  gen_mask = 8'hFF;
  logic [15:0] ch_fault_in = '0;
  logic twarn_in = 1'b0, tshdn_in = 1'b0, ovp_in = 1'b0;
  logic [1:0] ol_req = '0, retry = '0, clr_ch = '0;
  logic clr_gen = 1'b0;
  logic [15:0] ch_status;
  logic [7:0]  gen_status;
  logic [1:0]  ch_hiz, ch_on;
  logic mute_out, flag_n, flag_sum;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_diag_ctrl #(.NCH(NCH), .OL_CYCLES(OLC)) i_fault_diag_ctrl (
    .clk(clk), .rst(rst), .diag_en(diag_en), .en_bit(en_bit), .shdn_n(shdn_n),
    .mute_bit(mute_bit), .mute_n(mute_n), .ch_mask(ch_mask), .gen_mask(gen_mask),
    .ch_fault_in(ch_fault_in), .twarn_in(twarn_in), .tshdn_in(tshdn_in),
    .ovp_in(ovp_in), .ol_req(ol_req), .retry(retry), .clr_ch(clr_ch),
    .clr_gen(clr_gen), .ch_status(ch_status), .gen_status(gen_status),
    .ch_hiz(ch_hiz), .ch_on(ch_on), .mute_out(mute_out), .flag_n(flag_n),
    .flag_sum(flag_sum)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flag(input string req, input logic exp_n);
    chk(req, {31'd0, flag_n}, {31'd0, exp_n});
    chk(req, {31'd0, flag_sum}, {31'd0, ~exp_n});
  endtask

  task automatic clear_all();
    ch_fault_in = '0; twarn_in = 0; tshdn_in = 0; ovp_in = 0;
    clr_ch = 2'b11; clr_gen = 1'b1;
    step(1);
    clr_ch = '0; clr_gen = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    step(2);
    chk("R13 status", {16'd0, ch_status}, 32'd0);
    chk("R13 gen", {24'd0, gen_status}, 32'd0);
    chk("R13 hiz/on", {28'd0, ch_hiz, ch_on}, 32'd0);
    chk("R13 mute", {31'd0, mute_out}, 32'd1);
    chk_flag("R13 flag", 1'b1);
    rst = 1'b0;
    step(1);
    chk("R10 on after reset", {30'd0, ch_on}, 32'd3);
    chk("R10 unmuted", {31'd0, mute_out}, 32'd0);
  endtask

  task automatic t_mask();
    diag_en = 1'b0;
    ch_fault_in[5] = 1'b1;
    step(1);
    chk("R1 diag off", {16'd0, ch_status}, 32'd0);
    diag_en = 1'b1;
    ch_mask[5] = 1'b0;
    step(1);
    chk("R1 masked", {16'd0, ch_status}, 32'd0);
    chk_flag("R9 no fault", 1'b1);
    ch_mask[5] = 1'b1;
    step(1);
    chk("R2 ilim bit5", {16'd0, ch_status}, 32'h20);
    chk("R5 channel runs", {30'd0, ch_on}, 32'd3);
    chk_flag("R9 ilim flag", 1'b0);
    ch_fault_in[5] = 1'b0;
    step(3);
    chk("R12 sticky", {16'd0, ch_status}, 32'h20);
    ch_fault_in[5] = 1'b1; clr_ch[0] = 1'b1;
    step(1);
    chk("R12 set wins", {16'd0, ch_status}, 32'h20);
    ch_fault_in[5] = 1'b0;
    step(1);
    clr_ch[0] = 1'b0;
    step(1);
    chk("R12 cleared", {16'd0, ch_status}, 32'h0);
    chk_flag("R9 cleared", 1'b1);
  endtask

  task automatic t_short();
    ch_fault_in[15] = 1'b1;
    step(1);
    chk("R2 svdd ch1", {16'd0, ch_status}, 32'h8000);
    chk("R4 hiz", {30'd0, ch_hiz}, 32'd2);
    chk("R4 off", {30'd0, ch_on}, 32'd1);
    ch_fault_in[15] = 1'b0;
    step(3);
    chk("R4 stays off", {30'd0, ch_hiz}, 32'd2);
    ch_mask[14] = 1'b0; ch_fault_in[14] = 1'b1; retry[1] = 1'b1;
    step(1);
    retry[1] = 1'b0;
    step(1);
    chk("R11 blocked retry", {30'd0, ch_hiz}, 32'd2);
    chk("R11 still off", {30'd0, ch_on}, 32'd1);
    ch_fault_in[14] = 1'b0; ch_mask[14] = 1'b1; retry[1] = 1'b1;
    step(1);
    retry[1] = 1'b0;
    chk("R4 retry clears", {30'd0, ch_hiz}, 32'd0);
    chk("R4 back on", {30'd0, ch_on}, 32'd3);
    clear_all();
  endtask

  task automatic t_ovp();
    gen_mask = 8'h00;
    ovp_in = 1'b1;
    step(1);
    chk("R3 ovp unmaskable", {24'd0, gen_status}, 32'h10);
    chk("R7 both hiz", {30'd0, ch_hiz}, 32'd3);
    chk("R7 both off", {30'd0, ch_on}, 32'd0);
    chk_flag("R9 ovp flag", 1'b0);
    retry = 2'b11;
    step(1);
    chk("R11 ovp blocks retry", {30'd0, ch_hiz}, 32'd3);
    ovp_in = 1'b0;
    step(1);
    retry = 2'b00;
    chk("R11 retry after ovp", {30'd0, ch_on}, 32'd3);
    chk("R12 gen sticky", {24'd0, gen_status}, 32'h10);
    clear_all();
    twarn_in = 1'b1;
    step(1);
    chk("R1 twarn masked", {24'd0, gen_status}, 32'h0);
    gen_mask = 8'h60;
    step(1);
    chk("R3 twarn bit6", {24'd0, gen_status}, 32'h40);
    twarn_in = 1'b0; tshdn_in = 1'b1;
    step(1);
    chk("R3 tshdn bit5", {24'd0, gen_status}, 32'h60);
    chk("R3 temp keeps on", {30'd0, ch_on}, 32'd3);
    gen_mask = 8'hFF;
    clear_all();
  endtask

  task automatic t_offset();
    ch_fault_in[3] = 1'b1;
    step(1);
    chk("R6 unmuted ignored", {16'd0, ch_status}, 32'h0);
    mute_n = 1'b0;
    step(1);
    chk("R10 pin mute", {31'd0, mute_out}, 32'd1);
    chk("R6 offset muted pin", {16'd0, ch_status}, 32'h08);
    clear_all();
    ch_fault_in[3] = 1'b1;
    mute_n = 1'b1; mute_bit = 1'b1;
    step(1);
    chk("R6 offset muted bit", {16'd0, ch_status}, 32'h08);
    mute_bit = 1'b0;
    clear_all();
    step(1);
    chk("R10 unmute", {31'd0, mute_out}, 32'd0);
  endtask

  task automatic t_ol();
    ch_fault_in[2] = 1'b1;
    step(2);
    chk("R8 open outside window", {16'd0, ch_status}, 32'h0);
    ol_req[0] = 1'b1;
    step(1);
    chk("R8 window starts", {30'd0, ch_on}, 32'd2);
    step(1);
    chk("R8 open in window", {16'd0, ch_status}, 32'h04);
    step(OLC - 2);
    chk("R8 last window cycle", {30'd0, ch_on}, 32'd2);
    step(1);
    chk("R8 window ends", {30'd0, ch_on}, 32'd3);
    ch_fault_in[2] = 1'b0;
    step(5);
    chk("R8 held req no rerun", {30'd0, ch_on}, 32'd3);
    clear_all();
    ol_req[0] = 1'b0;
    step(1);
    ol_req[0] = 1'b1;
    step(1);
    chk("R8 rerun", {30'd0, ch_on}, 32'd2);
    chk("R8 no open seen", {16'd0, ch_status}, 32'h0);
    step(OLC);
    chk("R8 rerun ends", {30'd0, ch_on}, 32'd3);
    ol_req[0] = 1'b0;
  endtask

  task automatic t_ctrl();
    shdn_n = 1'b0;
    step(1);
    chk("R10 shdn overrides", {30'd0, ch_on}, 32'd0);
    shdn_n = 1'b1; en_bit = 1'b0;
    step(1);
    chk("R10 enable off", {30'd0, ch_on}, 32'd0);
    en_bit = 1'b1;
    step(1);
    chk("R10 enable on", {30'd0, ch_on}, 32'd3);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_short();
    t_ovp();
    t_offset();
    t_ol();
    t_ctrl();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule